// File: doc/BRIEF.md
# Sized ALU Slice with Partial Register Writeback

This block is the arithmetic slice of a 32-bit processor datapath. It takes two operands, an operation code, an operand size and a destination register index. It computes a result combinationally and, when `valid_i` is high, writes that result into an internal 16-entry register file on the next rising clock edge.

Byte and halfword results replace only the low bits of the destination. A full-size result replaces the whole register. Multiplies keep the upper half of their 64-bit product in a separate overflow register. Compare and bit-test produce a result for the flag logic but never write the register file.

The slice also gives the downstream flag logic the values it needs: the carry-in that was used, the operand to treat as the flag source, and the masked result. Two combinational read ports let the surrounding datapath read the register file.

Top module: `alu_slice`

## Requirements
- R1: `size_i` selects the width. 2'b00 is byte, 2'b01 is halfword, and 2'b10 or 2'b11 is full word. For byte size, `result_o` is masked to its low 8 bits. For halfword size, it is masked to its low 16 bits.
- R2: A byte write replaces bits [7:0] of the destination and keeps bits [31:8]. A halfword write replaces bits [15:0] and keeps bits [31:16]. A full-word write replaces all 32 bits. The write takes effect at the rising edge where `valid_i` is high.
- R3: Compare (op 4) gives `a_i - b_i` on `result_o`. Bit-test (op 14) gives bit `b_i[4:0]` of `a_i` in bit 0 of `result_o`, with all other bits zero. Neither op writes the register file.
- R4: Bound (op 15) outputs `a_i` when `a_i <= b_i` as unsigned values. Otherwise it outputs `b_i`.
- R5: Unsigned multiply (op 17) and signed multiply (op 16) send the low 32 bits of the product to the result and the destination. The high 32 bits go to the overflow register `mof_o`. No other op changes `mof_o`.
- R6: Add-with-carry (op 1) adds `carry_i`. Alternate add-with-carry (op 2) adds `alt_carry_i` and ignores `carry_i`.
- R7: When `ext_i` is 1, the following ops chain `carry_i` into the calculation:
  - add (op 0) adds it;
  - subtract (op 3) and compare (op 4) subtract it as a borrow;
  - negate (op 5) subtracts it as a borrow.
  When `ext_i` is 0, `carry_i` has no effect on these ops.
- R8: `fl_src_o` is `~b_i` for subtract and compare, and `b_i` for every other op. `cin_o` is the carry or borrow bit that was applied.
- R9: Leading-zero (op 13) returns the number of leading zero bits of `b_i`, from 0 to 32. Negate (op 5) returns `-b_i`.
- R10: Shift ops take their amount from `b_i`: left (op 10), logical right (op 11) and arithmetic right (op 12). An amount of 32 or more gives zero for the logical shifts and a full copy of `a_i[31]` for the arithmetic right shift.
- R11: Op codes 18 to 31 are illegal. They raise `error_o`, give a zero result, and write neither the register file nor `mof_o`.
- R12: Reset clears all registers and `mof_o` to zero.
- R13: The remaining ops compute as follows:
  - op 6 (move) returns `b_i`;
  - op 7 returns `a_i & b_i`;
  - op 8 returns `a_i | b_i`;
  - op 9 returns `a_i ^ b_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Commit the current operation at the next edge |
| op_i | input | 5 | Operation code |
| size_i | input | 2 | Operand size |
| rd_i | input | 4 | Destination register index |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| carry_i | input | 1 | Current carry flag |
| ext_i | input | 1 | Extended-arithmetic flag |
| alt_carry_i | input | 1 | Alternate carry flag for op 2 |
| result_o | output | 32 | Masked result |
| cin_o | output | 1 | Carry or borrow that was applied |
| fl_src_o | output | 32 | Source operand value for the flag logic |
| error_o | output | 1 | Illegal op code |
| mof_o | output | 32 | Multiply overflow register |
| rp0_idx_i | input | 4 | Read port 0 index |
| rp0_data_o | output | 32 | Read port 0 data |
| rp1_idx_i | input | 4 | Read port 1 index |
| rp1_data_o | output | 32 | Read port 1 data |

## Verification
`result_o`, `cin_o`, `fl_src_o` and `error_o` are combinational. They are due in the same cycle that the inputs are applied, so the bench drives inputs on the falling edge and samples these outputs a quarter period later, before the rising edge.

Register-file and `mof_o` updates appear one rising edge after a cycle with `valid_i` high. The bench drops `valid_i` on the next falling edge and reads the destination through a read port in the low phase after that edge.

Checks that nothing was written read the same register back after the edge and compare it with its earlier value.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD   = 5'd0,
    OP_ADDC  = 5'd1,
    OP_ADDR  = 5'd2,
    OP_SUB   = 5'd3,
    OP_CMP   = 5'd4,
    OP_NEG   = 5'd5,
    OP_MOVE  = 5'd6,
    OP_AND   = 5'd7,
    OP_OR    = 5'd8,
    OP_XOR   = 5'd9,
    OP_LSL   = 5'd10,
    OP_LSR   = 5'd11,
    OP_ASR   = 5'd12,
    OP_LZ    = 5'd13,
    OP_BTST  = 5'd14,
    OP_BOUND = 5'd15,
    OP_MULS  = 5'd16,
    OP_MULU  = 5'd17
  } alu_op_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
endpackage

// File: rtl/alu_lzc.sv
module alu_lzc #(
  parameter int W  = 32,
  localparam int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  val_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    cnt_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found) begin
        if (val_i[i]) found = 1'b1;
        else cnt_o = cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [4:0]   op_i,
  input  logic [1:0]   size_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         carry_i,
  input  logic         ext_i,
  input  logic         alt_carry_i,
  output logic [W-1:0] res_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] src_o,
  output logic         cin_o,
  output logic         err_o,
  output logic         no_wb_o,
  output logic         is_mul_o
);
  localparam int SHW = $clog2(W);
  localparam int CW  = SHW + 1;
  localparam int DW  = 2 * W;

  logic [CW-1:0]    lz_cnt;
  logic [SHW-1:0]   sh_amt;
  logic             sh_big;
  logic [DW-1:0]    prod;
  logic [W-1:0]     raw;
  logic             xc;

  alu_lzc #(.W(W)) u_lzc (.val_i(b_i), .cnt_o(lz_cnt));

  assign sh_amt = b_i[SHW-1:0];
  assign sh_big = |b_i[W-1:SHW];
  assign xc     = ext_i & carry_i;

  always_comb begin
    raw      = '0;
    prod     = '0;
    src_o    = b_i;
    cin_o    = 1'b0;
    err_o    = 1'b0;
    no_wb_o  = 1'b0;
    is_mul_o = 1'b0;
    case (op_i)
      OP_ADD:  begin cin_o = xc;          raw = a_i + b_i + W'(cin_o); end
      OP_ADDC: begin cin_o = carry_i;     raw = a_i + b_i + W'(cin_o); end
      OP_ADDR: begin cin_o = alt_carry_i; raw = a_i + b_i + W'(cin_o); end
      OP_SUB:  begin cin_o = xc; src_o = ~b_i; raw = a_i - b_i - W'(cin_o); end
      OP_CMP:  begin
        cin_o = xc; src_o = ~b_i; no_wb_o = 1'b1;
        raw = a_i - b_i - W'(cin_o);
      end
      OP_NEG:  begin cin_o = xc; raw = '0 - b_i - W'(cin_o); end
      OP_MOVE: raw = b_i;
      OP_AND:  raw = a_i & b_i;
      OP_OR:   raw = a_i | b_i;
      OP_XOR:  raw = a_i ^ b_i;
      OP_LSL:  raw = sh_big ? '0 : (a_i << sh_amt);
      OP_LSR:  raw = sh_big ? '0 : (a_i >> sh_amt);
      OP_ASR:  raw = sh_big ? {W{a_i[W-1]}} : W'($signed(a_i) >>> sh_amt);
      OP_LZ:   raw = W'(lz_cnt);
      OP_BTST: begin no_wb_o = 1'b1; raw = W'(a_i[sh_amt]); end
      OP_BOUND: raw = (a_i <= b_i) ? a_i : b_i;
      OP_MULS: begin
        is_mul_o = 1'b1;
        prod = {{W{a_i[W-1]}}, a_i} * {{W{b_i[W-1]}}, b_i};
        raw  = prod[W-1:0];
      end
      OP_MULU: begin
        is_mul_o = 1'b1;
        prod = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
        raw  = prod[W-1:0];
      end
      default: begin err_o = 1'b1; no_wb_o = 1'b1; end
    endcase
  end

  assign hi_o = prod[DW-1:W];

  always_comb begin
    case (size_i)
      SZ_BYTE: res_o = {{(W-8){1'b0}}, raw[7:0]};
      SZ_HALF: res_o = {{(W-16){1'b0}}, raw[15:0]};
      default: res_o = raw;
    endcase
  end
endmodule

// File: rtl/alu_regfile.sv
module alu_regfile
  import alu_pkg::*;
#(
  parameter int W    = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [1:0]    wsize_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [IW-1:0] ra0_i,
  output logic [W-1:0]  rd0_o,
  input  logic [IW-1:0] ra1_i,
  output logic [W-1:0]  rd1_o
);
  logic [W-1:0] regs_q [NREG];
  logic [W-1:0] merged;
  logic [W-1:0] old;

  assign old = regs_q[waddr_i];

  // sub-word writes keep the destination's upper bits
  always_comb begin
    case (wsize_i)
      SZ_BYTE: merged = {old[W-1:8], wdata_i[7:0]};
      SZ_HALF: merged = {old[W-1:16], wdata_i[15:0]};
      default: merged = wdata_i;
    endcase
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (we_i && waddr_i == IW'(g)) regs_q[g] <= merged;
    end
  end

  assign rd0_o = regs_q[ra0_i];
  assign rd1_o = regs_q[ra1_i];
endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
#(
  parameter int W    = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [4:0]    op_i,
  input  logic [1:0]    size_i,
  input  logic [IW-1:0] rd_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic          carry_i,
  input  logic          ext_i,
  input  logic          alt_carry_i,
  output logic [W-1:0]  result_o,
  output logic          cin_o,
  output logic [W-1:0]  fl_src_o,
  output logic          error_o,
  output logic [W-1:0]  mof_o,
  input  logic [IW-1:0] rp0_idx_i,
  output logic [W-1:0]  rp0_data_o,
  input  logic [IW-1:0] rp1_idx_i,
  output logic [W-1:0]  rp1_data_o
);
  logic [W-1:0] hi;
  logic         no_wb;
  logic         is_mul;
  logic         rf_we;
  logic         mof_we;
  logic [W-1:0] mof_q;

  alu_exec #(.W(W)) u_exec (
    .op_i(op_i), .size_i(size_i), .a_i(a_i), .b_i(b_i),
    .carry_i(carry_i), .ext_i(ext_i), .alt_carry_i(alt_carry_i),
    .res_o(result_o), .hi_o(hi), .src_o(fl_src_o), .cin_o(cin_o),
    .err_o(error_o), .no_wb_o(no_wb), .is_mul_o(is_mul)
  );

  assign rf_we  = valid_i & ~no_wb;
  assign mof_we = valid_i & is_mul;

  alu_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(rf_we), .waddr_i(rd_i),
    .wsize_i(size_i), .wdata_i(result_o),
    .ra0_i(rp0_idx_i), .rd0_o(rp0_data_o),
    .ra1_i(rp1_idx_i), .rd1_o(rp1_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mof_q <= '0;
    else if (mof_we) mof_q <= hi;
  end

  assign mof_o = mof_q;
endmodule

// File: rtl/alu_slice_chk.sv
module alu_slice_chk
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [4:0]   op_i,
  input logic [1:0]   size_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] result_o,
  input logic         error_o,
  input logic [W-1:0] mof_o,
  input logic         rf_we_i,
  input logic         mof_we_i
);
  p_byte_mask_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_i == SZ_BYTE |-> result_o[W-1:8] == '0);

  p_half_mask_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_i == SZ_HALF |-> result_o[W-1:16] == '0);

  p_no_wb_test_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_CMP || op_i == OP_BTST) |-> !rf_we_i);

  p_bound_min_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_BOUND |-> (result_o <= a_i && result_o <= b_i));

  p_mof_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && (op_i == OP_MULS || op_i == OP_MULU)) |=> $stable(mof_o));

  p_illegal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (!rf_we_i && !mof_we_i && result_o == '0));
endmodule

bind alu_slice alu_slice_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .size_i(size_i), .a_i(a_i), .b_i(b_i), .result_o(result_o),
  .error_o(error_o), .mof_o(mof_o), .rf_we_i(rf_we), .mof_we_i(mof_we)
);

// File: tb/tb_alu_slice.sv
module tb_alu_slice;
  import alu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [4:0]  op = '0;
  logic [1:0]  size = 2'b10;
  logic [3:0]  rd = '0;
  logic [31:0] a = '0, b = '0;
  logic        c = 1'b0, x = 1'b0, r = 1'b0;
  logic [31:0] result, fl_src, mof, rp0_data, rp1_data;
  logic        cin, err;
  logic [3:0]  rp0_idx = '0, rp1_idx = '0;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  alu_slice dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .size_i(size),
    .rd_i(rd), .a_i(a), .b_i(b), .carry_i(c), .ext_i(x), .alt_carry_i(r),
    .result_o(result), .cin_o(cin), .fl_src_o(fl_src), .error_o(err),
    .mof_o(mof), .rp0_idx_i(rp0_idx), .rp0_data_o(rp0_data),
    .rp1_idx_i(rp1_idx), .rp1_data_o(rp1_data)
  );

  typedef struct packed {
    logic [4:0]  op;
    logic [1:0]  sz;
    logic [31:0] a;
    logic [31:0] b;
    logic [2:0]  cxr;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VT [NV] = '{
    '{OP_ADD,   2'd2, 32'd5, 32'd7, 3'b100, 32'd12, 4'd7},           // R7
    '{OP_ADD,   2'd2, 32'd5, 32'd7, 3'b110, 32'd13, 4'd7},           // R7
    '{OP_ADDC,  2'd2, 32'hFFFFFFFF, 32'd0, 3'b100, 32'd0, 4'd6},     // R6
    '{OP_ADDC,  2'd2, 32'd1, 32'd1, 3'b000, 32'd2, 4'd6},            // R6
    '{OP_ADDR,  2'd2, 32'd10, 32'd20, 3'b001, 32'd31, 4'd6},         // R6
    '{OP_ADDR,  2'd2, 32'd10, 32'd20, 3'b100, 32'd30, 4'd6},         // R6
    '{OP_SUB,   2'd2, 32'd10, 32'd3, 3'b100, 32'd7, 4'd7},           // R7
    '{OP_SUB,   2'd2, 32'd10, 32'd3, 3'b110, 32'd6, 4'd7},           // R7
    '{OP_NEG,   2'd2, 32'd0, 32'd1, 3'b000, 32'hFFFFFFFF, 4'd9},     // R9
    '{OP_NEG,   2'd2, 32'd0, 32'd1, 3'b110, 32'hFFFFFFFE, 4'd7},     // R7
    '{OP_LZ,    2'd2, 32'd0, 32'h00010000, 3'b000, 32'd15, 4'd9},    // R9
    '{OP_LZ,    2'd2, 32'd0, 32'd0, 3'b000, 32'd32, 4'd9},           // R9
    '{OP_LZ,    2'd2, 32'd0, 32'h80000000, 3'b000, 32'd0, 4'd9},     // R9
    '{OP_AND,   2'd2, 32'hF0F0F0F0, 32'hFF00FF00, 3'b000, 32'hF000F000, 4'd13}, // R13
    '{OP_OR,    2'd2, 32'hF0F0F0F0, 32'hFF00FF00, 3'b000, 32'hFFF0FFF0, 4'd13}, // R13
    '{OP_XOR,   2'd2, 32'hF0F0F0F0, 32'hFF00FF00, 3'b000, 32'h0FF00FF0, 4'd13}, // R13
    '{OP_MOVE,  2'd2, 32'd0, 32'hDEADBEEF, 3'b000, 32'hDEADBEEF, 4'd13},        // R13
    '{OP_LSL,   2'd2, 32'd1, 32'd4, 3'b000, 32'd16, 4'd10},          // R10
    '{OP_LSL,   2'd2, 32'd1, 32'd32, 3'b000, 32'd0, 4'd10},          // R10
    '{OP_LSR,   2'd2, 32'h80000000, 32'd31, 3'b000, 32'd1, 4'd10},   // R10
    '{OP_LSR,   2'd2, 32'h80000000, 32'd40, 3'b000, 32'd0, 4'd10},   // R10
    '{OP_ASR,   2'd2, 32'h80000000, 32'd4, 3'b000, 32'hF8000000, 4'd10},  // R10
    '{OP_ASR,   2'd2, 32'h80000000, 32'd100, 3'b000, 32'hFFFFFFFF, 4'd10},// R10
    '{OP_ASR,   2'd2, 32'h40000000, 32'd33, 3'b000, 32'd0, 4'd10},   // R10
    '{OP_BOUND, 2'd2, 32'd5, 32'd9, 3'b000, 32'd5, 4'd4},            // R4
    '{OP_BOUND, 2'd2, 32'hFFFFFFF0, 32'd9, 3'b000, 32'd9, 4'd4},     // R4
    '{OP_BOUND, 2'd2, 32'd9, 32'd9, 3'b000, 32'd9, 4'd4},            // R4
    '{OP_CMP,   2'd2, 32'd3, 32'd5, 3'b000, 32'hFFFFFFFE, 4'd3},     // R3
    '{OP_BTST,  2'd2, 32'h100, 32'd8, 3'b000, 32'd1, 4'd3},          // R3
    '{OP_BTST,  2'd2, 32'h100, 32'd7, 3'b000, 32'd0, 4'd3},          // R3
    '{OP_ADD,   2'd0, 32'h1FF, 32'd1, 3'b000, 32'd0, 4'd1},          // R1
    '{OP_ADD,   2'd1, 32'h1234FFFF, 32'd2, 3'b000, 32'd1, 4'd1},     // R1
    '{OP_MULU,  2'd2, 32'hFFFFFFFF, 32'd2, 3'b000, 32'hFFFFFFFE, 4'd5}, // R5
    '{OP_MULS,  2'd2, 32'hFFFFFFFF, 32'd2, 3'b000, 32'hFFFFFFFE, 4'd5}, // R5
    '{OP_LSL,   2'd0, 32'h81, 32'd1, 3'b000, 32'h02, 4'd1}           // R1
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] o, input logic [1:0] s, input logic [3:0] d,
                       input logic [31:0] va, input logic [31:0] vb,
                       input logic [2:0] f, input logic v);
    @(negedge clk);
    op = o; size = s; rd = d; a = va; b = vb;
    {c, x, r} = f; valid = v;
    #5;
  endtask

  // finish a committed op: let the edge pass, drop valid, sample in low phase
  task automatic commit();
    @(negedge clk);
    valid = 1'b0;
    #5;
  endtask

  initial begin
    #(20 * 100000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    for (int i = 0; i < 16; i++) begin
      rp0_idx = 4'(i);
      #1;
      chk("R12 reg reset", rp0_data, 32'd0);
    end
    chk("R12 mof reset", mof, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VT[i].op, VT[i].sz, 4'd0, VT[i].a, VT[i].b, VT[i].cxr, 1'b0);
      chk($sformatf("R%0d vector %0d", VT[i].req, i), result, VT[i].exp);
    end

    // R8: flag source and carry-in
    apply(OP_SUB, 2'd2, 4'd0, 32'd10, 32'd3, 3'b110, 1'b0);
    chk("R8 sub src", fl_src, 32'hFFFFFFFC);
    chk("R8 sub cin", {31'd0, cin}, 32'd1);
    apply(OP_CMP, 2'd2, 4'd0, 32'd10, 32'd3, 3'b000, 1'b0);
    chk("R8 cmp src", fl_src, 32'hFFFFFFFC);
    apply(OP_ADD, 2'd2, 4'd0, 32'd10, 32'd3, 3'b100, 1'b0);
    chk("R8 add src", fl_src, 32'd3);
    chk("R8 add cin x clear", {31'd0, cin}, 32'd0);

    // R2: full, byte and halfword writeback merge
    rp0_idx = 4'd3;
    rp1_idx = 4'd3;
    apply(OP_MOVE, 2'd2, 4'd3, 32'd0, 32'hAABBCCDD, 3'b000, 1'b1);
    commit();
    chk("R2 full write", rp0_data, 32'hAABBCCDD);
    apply(OP_MOVE, 2'd0, 4'd3, 32'd0, 32'h12345611, 3'b000, 1'b1);
    commit();
    chk("R2 byte merge", rp1_data, 32'hAABBCC11);
    apply(OP_MOVE, 2'd1, 4'd3, 32'd0, 32'h12345678, 3'b000, 1'b1);
    commit();
    chk("R2 half merge", rp0_data, 32'hAABB5678);

    // R3: compare and bit-test leave the destination alone
    apply(OP_CMP, 2'd2, 4'd3, 32'd1, 32'd2, 3'b000, 1'b1);
    commit();
    chk("R3 cmp no write", rp0_data, 32'hAABB5678);
    apply(OP_BTST, 2'd2, 4'd3, 32'hFFFFFFFF, 32'd0, 3'b000, 1'b1);
    commit();
    chk("R3 btst no write", rp0_data, 32'hAABB5678);

    // R11: illegal op
    apply(5'd25, 2'd2, 4'd3, 32'd1, 32'd1, 3'b000, 1'b1);
    chk("R11 error flag", {31'd0, err}, 32'd1);
    chk("R11 zero result", result, 32'd0);
    commit();
    chk("R11 no write", rp0_data, 32'hAABB5678);
    chk("R11 mof kept", mof, 32'd0);
    apply(OP_ADD, 2'd2, 4'd0, 32'd1, 32'd1, 3'b000, 1'b0);
    chk("R11 legal no error", {31'd0, err}, 32'd0);

    // R5: multiply high half
    rp0_idx = 4'd4;
    apply(OP_MULU, 2'd2, 4'd4, 32'hFFFFFFFF, 32'hFFFFFFFF, 3'b000, 1'b1);
    commit();
    chk("R5 mulu low", rp0_data, 32'h00000001);
    chk("R5 mulu high", mof, 32'hFFFFFFFE);
    apply(OP_ADD, 2'd2, 4'd5, 32'd1, 32'd2, 3'b000, 1'b1);
    commit();
    chk("R5 mof held by add", mof, 32'hFFFFFFFE);
    apply(OP_MULS, 2'd2, 4'd4, 32'hFFFFFFFE, 32'd3, 3'b000, 1'b1);
    commit();
    chk("R5 muls low", rp0_data, 32'hFFFFFFFA);
    chk("R5 muls high", mof, 32'hFFFFFFFF);
    apply(OP_MULS, 2'd2, 4'd4, 32'hFFFFFFFF, 32'hFFFFFFFF, 3'b000, 1'b1);
    commit();
    chk("R5 muls neg*neg high", mof, 32'd0);
    chk("R5 muls neg*neg low", rp0_data, 32'd1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule